// File: doc/BRIEF.md
# Two-wire bus write master with arbitration

This block is the master side of a two-wire serial bus, for writes only. It generates a START condition and clocks out a series of bytes. Each byte is followed by an acknowledge slot. The block ends the transfer with a STOP condition. Both lines are open drain. The block only ever pulls a line low, and a released line goes high through the external pull-up. The block drives every SCL pulse itself. It does not wait on a slave that holds SCL low.

Software or a sequencer asks for a START, and the engine then waits with SCL held low. While it waits it takes a byte over a valid/ready handshake, a repeated START, or a STOP. After each byte the engine reports the acknowledge level it sampled and returns to the waiting state. The engine reads SDA back through a synchronizer on every bit it releases. If another master holds the line low on such a bit, the engine lets go of both lines at once. It then raises a sticky arbitration-lost flag and drops the transfer.

Top module: `i2c_wr_master`

## Requirements
- R1: While reset is asserted, and after it is released, both line enables are 0 (released). `ready_o`, `ack_valid_o` and `arb_lost_o` are 0.
- R2: `start_i` in the idle state produces a START: SDA falls while SCL is released high. The engine then pulls SCL low and waits with `ready_o` high.
- R3: Outside the START and STOP sequences, `sda_oe_o` changes only in cycles where SCL is pulled low in the current cycle or the one before.
- R4: A byte goes out most significant bit first, one bit per SCL pulse, for `DATA_W` pulses. One more SCL pulse follows, during which `sda_oe_o` is 0.
- R5: The acknowledge level is sampled in the middle of the ninth pulse's high phase. It appears on `ack_o` (0 = acknowledged, 1 = not acknowledged) with a one-cycle `ack_valid_o` pulse. The engine then waits with SCL pulled low until a STOP, a repeated START or a new byte is requested.
- R6: Suppose the engine releases SDA for a data bit but samples it low. The engine then releases both lines in the same cycle that `arb_lost_o` rises, and produces no further SCL pulse.
- R7: `arb_lost_o` stays set until `start_i` is seen in the idle state. That cycle clears it. A `stop_i` does not clear it.
- R8: `stop_i` in the waiting state produces a STOP. SCL is released first, then SDA rises while SCL is high. After that both lines stay released.
- R9: `start_i` in the waiting state produces a repeated START. SDA is released while SCL is low, SCL is released, and then SDA falls while SCL is high.
- R10: `ready_o` is 1 only in the waiting state while `start_i` and `stop_i` are both 0. A byte is taken in the cycle where `valid_i` and `ready_o` are both 1.
- R11: When requests arrive together in the waiting state, `stop_i` wins over `start_i`, and `start_i` wins over `valid_i`. A losing byte is not sent.
- R12: Each SCL period lasts `4*QUARTER_CYC` clock cycles, and its high phase lasts `2*QUARTER_CYC`.
- R13: In the idle state, `stop_i` and `valid_i` have no effect: both lines stay released and `ready_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request START (from idle) or repeated START (while waiting) |
| stop_i | input | 1 | Request STOP while waiting |
| valid_i | input | 1 | Byte on `data_i` is valid |
| data_i | input | DATA_W | Byte to send, MSB first |
| ready_o | output | 1 | Engine takes a byte this cycle if `valid_i` is 1 |
| ack_valid_o | output | 1 | One-cycle pulse when `ack_o` is updated |
| ack_o | output | 1 | Sampled acknowledge level: 0 acknowledged, 1 not |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The bench builds the block with `QUARTER_CYC` = 3, `SYNC_STAGES` = 2 and `DATA_W` = 8. The short quarter keeps each byte near a hundred cycles, so many transfers fit in a short run: plain, repeated-START, request-collision and arbitration runs. Two synchronizer stages against a three-cycle quarter is the tightest pair the sampling point allows. With this pair, acknowledge and arbitration reads come from a bus value taken just after SCL rises. A slave model that can acknowledge or not, and a rival master that holds SDA low, supply the NACK and the lost-arbitration cases.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HOLD,
    ST_DATA,
    ST_STOP
  } eng_state_e;

  typedef logic [1:0] quarter_t;

  localparam quarter_t Q_LAST = 2'd3;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] r_q;
      // reset to the idle bus level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '1;
        else         r_q <= STAGES'({r_q, d_i});
      end
      assign q_o = r_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cw_qtimer.sv
module i2cw_qtimer
  import i2cw_pkg::*;
#(
  parameter int QUARTER_CYC = 125
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  quarter_t load_q_i,
  input  logic     run_i,
  output quarter_t q_o,
  output logic     qend_o,
  output logic     mid_o
);
  localparam int CW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(QUARTER_CYC - 1);

  logic [CW-1:0] cnt_q;
  quarter_t      q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      q_q   <= load_q_i;
    end else if (run_i) begin
      if (cnt_q == CNT_MAX) begin
        cnt_q <= '0;
        q_q   <= q_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o    = q_q;
  assign qend_o = run_i && (cnt_q == CNT_MAX);
  // first cycle of the second high quarter
  assign mid_o  = run_i && (q_q == Q_LAST) && (cnt_q == '0);

  p_quarter_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && qend_o) |=> (q_o == 2'($past(q_o) + 2'd1)));
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sda_s_i,
  input  quarter_t          q_i,
  input  logic              qend_i,
  input  logic              mid_i,
  output logic              load_o,
  output quarter_t          load_q_o,
  output logic              run_o,
  output logic              ready_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              arb_lost_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(DATA_W);

  eng_state_e        state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              arb_q, arb_d, ack_q, ack_d, ackv_q, ackv_d;
  logic              arb_hit, slot_end;

  assign slot_end = qend_i && (q_i == Q_LAST);
  assign ready_o  = (state_q == ST_HOLD) && !start_i && !stop_i;
  assign run_o    = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    idx_d    = idx_q;
    arb_d    = arb_q;
    ack_d    = ack_q;
    ackv_d   = 1'b0;
    load_o   = 1'b0;
    load_q_o = 2'd0;
    arb_hit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_START;
          load_o   = 1'b1;
          load_q_o = 2'd1;  // SCL already high: skip the low quarter
          arb_d    = 1'b0;
        end
      end
      ST_HOLD: begin
        if (stop_i) begin
          state_d  = ST_STOP;
          load_o   = 1'b1;
          load_q_o = 2'd1;
        end else if (start_i) begin
          state_d  = ST_START;
          load_o   = 1'b1;
        end else if (valid_i) begin
          state_d  = ST_DATA;
          load_o   = 1'b1;
          sh_d     = data_i;
          idx_d    = '0;
        end
      end
      ST_START: if (slot_end) state_d = ST_HOLD;
      ST_STOP:  if (slot_end) state_d = ST_IDLE;
      ST_DATA: begin
        if (slot_end) begin
          if (idx_q == ACK_IDX) begin
            state_d = ST_HOLD;
          end else begin
            idx_d = idx_q + 1'b1;
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          end
        end
        if (mid_i) begin
          if (idx_q == ACK_IDX) begin
            ack_d  = sda_s_i;
            ackv_d = 1'b1;
          end else if (sh_q[DATA_W-1] && !sda_s_i) begin
            arb_hit = 1'b1;
            arb_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      arb_q   <= 1'b0;
      ack_q   <= 1'b0;
      ackv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      arb_q   <= arb_d;
      ack_q   <= ack_d;
      ackv_q  <= ackv_d;
    end
  end

  // line decode: quarters 0,1 low, 2,3 high
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_IDLE: ;
      ST_HOLD: begin
        scl_oe_o = 1'b1;
        sda_oe_o = 1'b1;
      end
      ST_START: begin
        scl_oe_o = (q_i == 2'd0);
        sda_oe_o = q_i[1];
      end
      ST_STOP: begin
        scl_oe_o = (q_i == 2'd0);
        sda_oe_o = (q_i != Q_LAST);
      end
      ST_DATA: begin
        scl_oe_o = !q_i[1];
        sda_oe_o = (idx_q != ACK_IDX) && !sh_q[DATA_W-1];
      end
      default: ;
    endcase
  end

  assign ack_o       = ack_q;
  assign ack_valid_o = ackv_q;
  assign arb_lost_o  = arb_q;

  p_sda_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (state_q == ST_START || state_q == ST_STOP));

  p_ack_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (!sda_oe_o && !scl_oe_o));

  p_arb_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_hit |=> (arb_lost_o && !scl_oe_o && !sda_oe_o));

  p_arb_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && !start_i) |=> arb_lost_o);

  p_ready_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (scl_oe_o && !start_i && !stop_i));
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2cw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int QUARTER_CYC = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              arb_lost_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic     sda_s, load, qend, mid, run;
  quarter_t load_q, q;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  i2cw_qtimer #(.QUARTER_CYC(QUARTER_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .load_q_i(load_q),
    .run_i   (run),
    .q_o     (q),
    .qend_o  (qend),
    .mid_o   (mid)
  );

  i2cw_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .valid_i    (valid_i),
    .data_i     (data_i),
    .sda_s_i    (sda_s),
    .q_i        (q),
    .qend_i     (qend),
    .mid_i      (mid),
    .load_o     (load),
    .load_q_o   (load_q),
    .run_o      (run),
    .ready_o    (ready_o),
    .ack_valid_o(ack_valid_o),
    .ack_o      (ack_o),
    .arb_lost_o (arb_lost_o),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );
endmodule

// File: tb/tb_i2c_wr_master.sv
module tb_i2c_wr_master;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 3;
  localparam int SYNC = 2;
  localparam int DW = 8;
  localparam logic [7:0] EV_START = 8'd1, EV_BYTE = 8'd2, EV_ACK = 8'd3, EV_STOP = 8'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic start, stop, valid, ready, ack_valid, ack, arb_lost, scl_oe, sda_oe;
  logic [DW-1:0] data;
  logic rival_pull, slave_pull, slave_ack, mon_en;
  logic scl_bus, sda_bus;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | rival_pull | slave_pull);

  i2c_wr_master #(.DATA_W(DW), .QUARTER_CYC(QC), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .valid_i(valid),
    .data_i(data), .ready_o(ready), .ack_valid_o(ack_valid), .ack_o(ack),
    .arb_lost_o(arb_lost), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_bus)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [7:0] k);
    case (k)
      EV_START: return "R2/R9 start";
      EV_BYTE:  return "R4 byte";
      EV_ACK:   return "R5 ack";
      default:  return "R8 stop";
    endcase
  endfunction

  task automatic got(input logic [15:0] ev);
    logic [15:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag_of(ev[15:8]), " unexpected"}, 32'(ev), 32'hffff);
    end else begin
      e = exp_q.pop_front();
      chk(ev == e, tag_of(e[15:8]), 32'(ev), 32'(e));
    end
  endtask

  // scoreboard monitor on the bus lines
  int cyc = 0, last_rise = 0, bitcnt = 0, rises = 0;
  logic scl_p = 1'b1, sda_p = 1'b1, hi_chk = 1'b0;
  logic [DW-1:0] sh = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      slave_pull = 1'b0;
      bitcnt = 0;
    end else begin
      if (scl_p && scl_bus && sda_p && !sda_bus) begin
        bitcnt = 0; hi_chk = 1'b0;
        if (mon_en) got({EV_START, 8'h00});
      end else if (scl_p && scl_bus && !sda_p && sda_bus) begin
        bitcnt = 0; hi_chk = 1'b0;
        if (mon_en) got({EV_STOP, 8'h00});
      end
      if (!scl_p && scl_bus) begin
        rises++;
        if (mon_en && bitcnt >= 1) chk(cyc - last_rise == 4 * QC, "R12 period", 32'(cyc - last_rise), 32'(4 * QC));
        last_rise = cyc;
        hi_chk = 1'b1;
        if (bitcnt < DW) begin
          sh = {sh[DW-2:0], sda_bus};
          bitcnt++;
        end else begin
          if (mon_en) chk(sda_oe == 1'b0, "R4 ack slot released", 32'(sda_oe), 32'd0);
          if (mon_en) got({EV_BYTE, sh});
          bitcnt = 0;
        end
      end
      if (scl_p && !scl_bus) begin
        if (mon_en && hi_chk) chk(cyc - last_rise == 2 * QC, "R12 high phase", 32'(cyc - last_rise), 32'(2 * QC));
        hi_chk = 1'b0;
        if (slave_pull) slave_pull = 1'b0;
        else if (bitcnt == DW) slave_pull = slave_ack;
      end
      if (mon_en && ack_valid) got({EV_ACK, 7'd0, ack});
    end
    scl_p = scl_bus;
    sda_p = sda_bus;
  end

  task automatic wait_hold();
    do @(negedge clk); while (!ready);
  endtask

  task automatic do_start();
    if (mon_en) exp_q.push_back({EV_START, 8'h00});
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_hold();
  endtask

  task automatic do_stop();
    exp_q.push_back({EV_STOP, 8'h00});
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    repeat (4 * QC + 4) @(negedge clk);
    chk(!scl_oe && !sda_oe && !ready, "R8 bus released after stop", 32'({scl_oe, sda_oe, ready}), 32'd0);
  endtask

  task automatic send_byte(input logic [DW-1:0] d, input logic acked);
    slave_ack = acked;
    exp_q.push_back({EV_BYTE, d});
    exp_q.push_back({EV_ACK, 7'd0, ~acked});
    @(negedge clk);
    data = d; valid = 1'b1;
    chk(ready == 1'b1, "R10 ready while waiting", 32'(ready), 32'd1);
    @(negedge clk) valid = 1'b0;
    wait_hold();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r0;
    bit ok;
    start = 0; stop = 0; valid = 0; data = '0;
    rival_pull = 0; slave_ack = 1; mon_en = 1;
    repeat (5) @(negedge clk);
    chk({scl_oe, sda_oe, ready, arb_lost, ack_valid} == 5'd0, "R1 in reset", 32'({scl_oe, sda_oe, ready, arb_lost, ack_valid}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, ready, arb_lost, ack_valid} == 5'd0, "R1 after reset", 32'({scl_oe, sda_oe, ready, arb_lost, ack_valid}), 32'd0);

    // plain transfer, mixed acknowledge
    do_start();
    chk(scl_oe == 1'b1, "R2 SCL held low after start", 32'(scl_oe), 32'd1);
    send_byte(8'hA5, 1'b1);
    send_byte(8'h00, 1'b1);
    send_byte(8'hFF, 1'b0);
    repeat (20) @(negedge clk);
    chk(scl_oe && ready && ack, "R5 waits after NACK", 32'({scl_oe, ready, ack}), 32'h7);
    send_byte(8'h81, 1'b1);
    do_stop();

    // idle ignores stop and byte requests (R13)
    ok = 1'b1;
    @(negedge clk);
    stop = 1'b1; valid = 1'b1; data = 8'h77;
    repeat (12 * QC) begin
      @(negedge clk);
      ok &= !scl_oe && !sda_oe && !ready;
    end
    stop = 1'b0; valid = 1'b0;
    chk(ok, "R13 idle ignores stop/valid", 32'(ok), 32'd1);

    // repeated start
    do_start();
    send_byte(8'h5A, 1'b1);
    do_start();
    send_byte(8'hC3, 1'b0);
    do_stop();

    // collisions in the waiting state (R11)
    do_start();
    exp_q.push_back({EV_STOP, 8'h00});
    @(negedge clk);
    stop = 1'b1; start = 1'b1; valid = 1'b1; data = 8'h11;
    #1 chk(ready == 1'b0, "R10 ready low with stop/start", 32'(ready), 32'd0);
    @(negedge clk) begin stop = 1'b0; start = 1'b0; valid = 1'b0; end
    repeat (4 * QC + 4) @(negedge clk);
    chk(exp_q.size() == 0 && !scl_oe && !sda_oe, "R11 stop wins", 32'(exp_q.size()), 32'd0);
    do_start();
    exp_q.push_back({EV_START, 8'h00});
    @(negedge clk);
    start = 1'b1; valid = 1'b1; data = 8'h22;
    #1 chk(ready == 1'b0, "R11 ready low under start", 32'(ready), 32'd0);
    @(negedge clk) begin start = 1'b0; valid = 1'b0; end
    wait_hold();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R11 start wins over byte", 32'(exp_q.size()), 32'd0);
    do_stop();

    // arbitration loss: rival holds SDA low, 0x3C loses on its third bit
    do_start();
    @(negedge clk);
    mon_en = 1'b0; rival_pull = 1'b1;
    r0 = rises;
    data = 8'h3C; valid = 1'b1;
    @(negedge clk) valid = 1'b0;
    while (!arb_lost) @(negedge clk);
    chk(rises - r0 == 3, "R6 pulses before loss", 32'(rises - r0), 32'd3);
    chk(!scl_oe && !sda_oe && !ready, "R6 lines released", 32'({scl_oe, sda_oe, ready}), 32'd0);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk(rises == r0, "R6 no further clock", 32'(rises - r0), 32'd0);
    chk(arb_lost == 1'b1, "R7 flag sticky", 32'(arb_lost), 32'd1);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(arb_lost == 1'b1, "R7 stop does not clear", 32'(arb_lost), 32'd1);
    rival_pull = 1'b0;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;
    exp_q.push_back({EV_START, 8'h00});
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(arb_lost == 1'b0, "R7 start clears flag", 32'(arb_lost), 32'd0);
    wait_hold();
    send_byte(8'h3C, 1'b1);
    do_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R4/R5/R8 all events seen", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule